// File: doc/BRIEF.md
# Register Rename Map Table with Free List

This block gives each architectural register write its own physical location, so that write-after-read and write-after-write conflicts between instructions disappear while true read-after-write dependences stay intact. A map table, indexed by architectural name, holds the physical location of each name's youngest write. A circular queue holds the physical locations that are not in use.

Each cycle one instruction may be presented with two source names and an optional destination name. The sources are translated through the map as it stands before this instruction. If there is a destination, the oldest free location is taken, written into the map for that name, and returned. The location the name held before is returned too, so that later logic can hand it back through the release port once no reader needs it. When no free location is left and the instruction has a destination, the block raises stall and changes nothing.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural name i maps to physical location i, for every name.
- R2: After reset, the free queue holds locations NUM_ARCH up to NUM_PHYS-1, and allocations hand them out in ascending order. For example, three writes in a row to one name receive NUM_ARCH, NUM_ARCH+1 and NUM_ARCH+2.
- R3: Sources are translated before the destination is remapped. An instruction that reads and writes the same name gets the old location on the source output and a new location on the destination output.
- R4: For an accepted write, prev_dst shows the location that the destination name held just before this instruction.
- R5: After an accepted write, later lookups of that name return the newly allocated location.
- R6: When in_valid and dst_valid are high and the free queue is empty, stall is high in that cycle. The map and the free queue stay unchanged. A release in that cycle does not clear the stall.
- R7: An instruction with dst_valid low never stalls, takes no free location and leaves the map unchanged.
- R8: A released location joins the tail of the free queue. It is handed out only after every location already in the queue.
- R9: A release and an allocation in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented |
| src_a | input | AW | First source name |
| src_b | input | AW | Second source name |
| dst_valid | input | 1 | The instruction writes a destination |
| dst | input | AW | Destination name |
| rel_valid | input | 1 | Return a location to the free queue |
| rel_loc | input | PW | Location being returned |
| phys_a | output | PW | Location for src_a |
| phys_b | output | PW | Location for src_b |
| phys_dst | output | PW | New location for dst (meaningful when accepted) |
| prev_dst | output | PW | Location dst held before this instruction |
| stall | output | 1 | Destination write refused because the free queue is empty |

## Verification
The case that is hardest to reach is the free queue running dry while a release arrives in the stalled cycle, followed by the released location being handed out strictly after the older entries. A directed sequence allocates every free location, then holds a write against the empty queue and releases one location. A seeded random phase follows. It recycles previous mappings through the release port, often in the same cycle as an allocation, and a bench model of the map and the queue predicts every output.

// File: rtl/reg_renamer.sv
module reg_renamer #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 24,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int FL_DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int FW = $clog2(FL_DEPTH),
  localparam int CW = $clog2(FL_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic          dst_valid,
  input  logic [AW-1:0] dst,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_loc,
  output logic [PW-1:0] phys_a,
  output logic [PW-1:0] phys_b,
  output logic [PW-1:0] phys_dst,
  output logic [PW-1:0] prev_dst,
  output logic          stall
);

  logic [PW-1:0] map_q [NUM_ARCH];
  logic [PW-1:0] fl_q  [FL_DEPTH];
  logic [FW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  logic empty, alloc;

  assign empty    = (cnt_q == '0);
  assign stall    = in_valid & dst_valid & empty;
  assign alloc    = in_valid & dst_valid & ~empty;
  assign phys_a   = map_q[src_a];
  assign phys_b   = map_q[src_b];
  assign prev_dst = map_q[dst];
  assign phys_dst = fl_q[head_q];

  function automatic logic [FW-1:0] wrap_inc(input logic [FW-1:0] p);
    return (p == FW'(FL_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
    end else if (alloc) begin
      map_q[dst] <= fl_q[head_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FL_DEPTH; i++) fl_q[i] <= PW'(NUM_ARCH + i);
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CW'(FL_DEPTH);
    end else begin
      if (alloc) head_q <= wrap_inc(head_q);
      if (rel_valid) begin
        fl_q[tail_q] <= rel_loc;
        tail_q       <= wrap_inc(tail_q);
      end
      if (alloc && !rel_valid)      cnt_q <= cnt_q - 1'b1;
      else if (!alloc && rel_valid) cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (cnt_q < CW'(FL_DEPTH)) || alloc);

  a_r9_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && rel_valid) |=> cnt_q == $past(cnt_q));

  a_r6_stall_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> head_q == $past(head_q));

  a_r7_no_dst_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dst_valid) |=> head_q == $past(head_q));

  a_r5_map_written: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> map_q[$past(dst)] == $past(phys_dst));

  a_r3_fresh_dst: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (phys_dst != prev_dst));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FL_DEPTH));

endmodule

// File: tb/sim_reg_renamer.sv
`timescale 1ns/1ps
module sim_reg_renamer;
  localparam int NA = 8;
  localparam int NP = 24;
  localparam int AW = $clog2(NA);
  localparam int PW = $clog2(NP);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, dst_valid = 0, rel_valid = 0;
  logic [AW-1:0] src_a = '0, src_b = '0, dst = '0;
  logic [PW-1:0] rel_loc = '0;
  logic [PW-1:0] phys_a, phys_b, phys_dst, prev_dst;
  logic stall;

  reg_renamer #(.NUM_ARCH(NA), .NUM_PHYS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .dst_valid(dst_valid), .dst(dst), .rel_valid(rel_valid), .rel_loc(rel_loc),
    .phys_a(phys_a), .phys_b(phys_b), .phys_dst(phys_dst), .prev_dst(prev_dst),
    .stall(stall));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int mmap [NA];
  int fl[$];
  int pend[$];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_stall(bit iv, bit dv);
    return iv && dv && (fl.size() == 0);
  endfunction

  task automatic step(bit iv, int sa, int sb, bit dv, int d, bit rv, int ri, string tag);
    bit st;
    int np;
    @(negedge clk);
    in_valid = iv; src_a = AW'(sa); src_b = AW'(sb);
    dst_valid = dv; dst = AW'(d); rel_valid = rv; rel_loc = PW'(ri);
    #2;
    st = exp_stall(iv, dv);
    chk({tag, " R6 stall"}, int'(stall), int'(st));
    if (iv) begin
      chk({tag, " R5 src_a"}, int'(phys_a), mmap[sa]);
      chk({tag, " R5 src_b"}, int'(phys_b), mmap[sb]);
    end
    if (iv && dv && !st) begin
      chk({tag, " R8 dst"}, int'(phys_dst), fl[0]);
      chk({tag, " R4 prev"}, int'(prev_dst), mmap[d]);
      np = fl.pop_front();
      pend.push_back(mmap[d]);
      mmap[d] = np;
    end
    if (rv) fl.push_back(ri);
    @(posedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int r;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < NA; i++) mmap[i] = i;
    for (int i = NA; i < NP; i++) fl.push_back(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 and R7: identity lookups, no destination
    for (int i = 0; i < NA; i += 2) begin
      @(negedge clk);
      in_valid = 1; dst_valid = 0; src_a = AW'(i); src_b = AW'(i + 1);
      #2;
      chk("R1 reset map a", int'(phys_a), i);
      chk("R1 reset map b", int'(phys_b), i + 1);
      chk("R7 no stall", int'(stall), 0);
      @(posedge clk);
    end

    // R2, R3: three writes to name 1, each also reading name 1
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1; dst_valid = 1; dst = 1; src_a = 1; src_b = 2;
      #2;
      chk("R2 alloc order", int'(phys_dst), NA + k);
      chk("R3 src old loc", int'(phys_a), (k == 0) ? 1 : NA + k - 1);
      chk("R4 prev map", int'(prev_dst), (k == 0) ? 1 : NA + k - 1);
      void'(fl.pop_front());
      pend.push_back(mmap[1]);
      mmap[1] = NA + k;
      @(posedge clk);
    end
    step(1, 1, 0, 0, 0, 0, 0, "R5 readback");
    chk("R5 name1 new loc", mmap[1], NA + 2);

    // drain free queue
    while (fl.size() > 0) step(1, 3, 4, 1, fl.size() % NA, 0, 0, "drain");

    // R6: stall while releasing; map unchanged
    r = pend.pop_front();
    step(1, 5, 5, 1, 5, 1, r, "R6 empty+rel");
    step(1, 5, 0, 0, 0, 0, 0, "R6 map kept");
    // R8: released location is next out
    @(negedge clk);
    in_valid = 1; dst_valid = 1; dst = 6; src_a = 6; src_b = 6; rel_valid = 0;
    #2;
    chk("R8 released next", int'(phys_dst), r);
    chk("R6 stall clear", int'(stall), 0);
    void'(fl.pop_front()); pend.push_back(mmap[6]); mmap[6] = r;
    @(posedge clk);

    // R8 ordering with two releases
    begin
      int r1, r2;
      r1 = pend.pop_front(); r2 = pend.pop_front();
      step(0, 0, 0, 0, 0, 1, r1, "R8 rel1");
      step(0, 0, 0, 0, 0, 1, r2, "R8 rel2");
      step(1, 0, 0, 1, 2, 0, 0, "R8 order1");
      step(1, 0, 0, 1, 2, 0, 0, "R8 order2");
    end

    // R9 directed: release and allocate together
    step(1, 2, 2, 1, 2, 1, pend.pop_front(), "R9 both");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit iv, dv, rv;
      int ri, idx;
      iv = ($urandom % 4) != 0;
      dv = ($urandom % 3) != 0;
      rv = (pend.size() > 0) && (($urandom % 5) < 2);
      ri = 0;
      if (rv) begin
        idx = $urandom % pend.size();
        ri = pend[idx];
        pend.delete(idx);
      end
      step(iv, $urandom % NA, $urandom % NA, dv, $urandom % NA, rv, ri, "R9 random");
    end

    in_valid = 0; rel_valid = 0;
    summary();
  end
endmodule